// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Receiver

This block receives asynchronous serial frames and hands each received byte to a host through a small register interface. Every frame carries one extra bit after the data byte, the address-mark bit, which tags the frame as an address (ID) frame when it is 1 and as a data frame when it is 0. Several stations can share one line: each station skips traffic addressed to others and wakes only when an ID frame arrives.

The host sets the ID-wait bit to enter filtering. While the bit is set, data frames are dropped without touching any flag. An ID frame is always accepted: it loads the data register, sets the receive-full flag and clears the ID-wait bit, so the data frames after it are delivered. The host reads the ID and compares it with its own. If the ID is not its own, the host sets ID-wait again and clears receive-full to return to filtering. Overrun and framing errors each have their own flag. While either flag is set, the receiver accepts no frames. The synchronized line level is readable so that the host can detect a break.

Top module: `mpr_rx`

## Requirements
- R1: After reset, receive-full, overrun, framing error and ID-wait read 0, the data register reads 0, and the line level reads 1 while the input idles high.
- R2: A frame is one low start bit, 8 data bits sent LSB first, the address-mark bit (1 = ID, 0 = data) and one high stop bit. Each bit lasts 16 oversample ticks and is sampled at its centre. With ID-wait at 0, every valid frame loads the byte into the data register and sets receive-full, whatever its address-mark bit.
- R3: While ID-wait is 1, a valid frame with address-mark 0 changes neither the data register, receive-full, ID-wait nor any error flag.
- R4: While ID-wait is 1, a valid frame with address-mark 1 loads the data register, sets receive-full and clears ID-wait.
- R5: Writing ID-wait back to 1 and pulsing the receive-full clear restores filtering. Data frames are then dropped again and the next ID frame is accepted again.
- R6: A valid frame that would be accepted while receive-full is 1 sets the overrun flag and leaves the data register unchanged.
- R7: A stop bit sampled low sets the framing error flag and leaves the data register and receive-full unchanged.
- R8: While the overrun or framing error flag is 1, incoming frames are not received. Reception resumes once both flags are cleared.
- R9: The receive-full, overrun and framing error flags each clear only through their own clear strobe, and a clear strobe leaves the other flags as they are.
- R10: The line-level output follows the serial input through a two-flop synchronizer. It stays low for as long as the line is held low (break).
- R11: A low pulse shorter than half a bit is rejected as a false start. No frame and no flag results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input, idles high |
| ctrl_wr_i | input | 1 | Write strobe for the ID-wait bit |
| ctrl_wdata_i | input | 1 | Value written to ID-wait |
| full_clr_i | input | 1 | Clears receive-full |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| ferr_clr_i | input | 1 | Clears the framing error flag |
| rdata_o | output | 8 | Receive data register |
| full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| ferr_o | output | 1 | Framing error flag |
| idwait_o | output | 1 | ID-wait bit |
| line_o | output | 1 | Synchronized serial line level |

## Verification
The bench builds the block with CLK_DIV = 1, so every clock is an oversample tick and one frame takes 176 clocks. At that rate the bench can send all 256 byte values, with alternating address-mark bits, through the data path and check each one. With the remaining cycles it runs the ID-wait sequence, overrun, framing error with a break, halting while errors are pending, and start glitch rejection. It builds every expected value from the byte it sent and the flag rules.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OS     = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BITS} rx_st_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              mark;
    logic              stop_ok;
  } frame_t;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/mpr_tick.sv
module mpr_tick #(
  parameter int unsigned CLK_DIV = 27
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           cnt_q <= '0;
        else if (cnt_q == CW'(CLK_DIV - 1))    cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/mpr_sampler.sv
module mpr_sampler
  import mpr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   en_i,
  input  logic   line_i,
  output logic   done_o,
  output frame_t frame_o
);
  localparam int unsigned NSH  = DATA_W + 1;        // data + mark
  localparam int unsigned NB   = NSH + 1;           // + stop
  localparam int unsigned BW   = $clog2(NB);
  localparam int unsigned OW   = $clog2(OS);
  localparam logic [OW-1:0] HALF = OW'(OS/2 - 1);
  localparam logic [OW-1:0] LAST = OW'(OS - 1);

  rx_st_e         st_q;
  logic [OW-1:0]  os_q;
  logic [BW-1:0]  bidx_q;
  logic [NSH-1:0] sh_q;
  logic           prev_q;
  logic           done_q;
  logic           stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      os_q   <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      prev_q <= 1'b1;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        prev_q <= line_i;
        unique case (st_q)
          ST_IDLE: begin
            if (en_i && prev_q && !line_i) begin
              st_q <= ST_START;
              os_q <= '0;
            end
          end
          ST_START: begin
            if (os_q == HALF) begin
              // confirm start at mid-bit
              st_q   <= line_i ? ST_IDLE : ST_BITS;
              os_q   <= '0;
              bidx_q <= '0;
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          ST_BITS: begin
            if (os_q == LAST) begin
              os_q <= '0;
              if (bidx_q == BW'(NB - 1)) begin
                done_q <= 1'b1;
                stop_q <= line_i;
                st_q   <= ST_IDLE;
              end else begin
                sh_q   <= {line_i, sh_q[NSH-1:1]};
                bidx_q <= bidx_q + 1'b1;
              end
            end else begin
              os_q <= os_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o          = done_q;
  assign frame_o.data    = sh_q[DATA_W-1:0];
  assign frame_o.mark    = sh_q[NSH-1];
  assign frame_o.stop_ok = stop_q;
endmodule

// File: rtl/mpr_rx.sv
module mpr_rx
  import mpr_pkg::*;
#(
  parameter int unsigned CLK_DIV = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_wdata_i,
  input  logic              full_clr_i,
  input  logic              ovr_clr_i,
  input  logic              ferr_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              ferr_o,
  output logic              idwait_o,
  output logic              line_o
);
  logic   line_s;
  logic   tick;
  logic   frm_done;
  frame_t frm;

  logic [DATA_W-1:0] rdata_q;
  logic full_q, ovr_q, ferr_q, idw_q;

  mpr_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  mpr_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  mpr_sampler u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .en_i   (!(ovr_q || ferr_q)),
    .line_i (line_s),
    .done_o (frm_done),
    .frame_o(frm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      ferr_q  <= 1'b0;
      idw_q   <= 1'b0;
    end else begin
      if (ctrl_wr_i)  idw_q  <= ctrl_wdata_i;
      if (full_clr_i) full_q <= 1'b0;
      if (ovr_clr_i)  ovr_q  <= 1'b0;
      if (ferr_clr_i) ferr_q <= 1'b0;
      // frame events take priority over same-cycle host writes
      if (frm_done) begin
        if (!frm.stop_ok) begin
          ferr_q <= 1'b1;
        end else if (idw_q && !frm.mark) begin
          // filtered data frame
        end else if (full_q) begin
          ovr_q <= 1'b1;
        end else begin
          rdata_q <= frm.data;
          full_q  <= 1'b1;
          if (frm.mark) idw_q <= 1'b0;
        end
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign full_o   = full_q;
  assign ovr_o    = ovr_q;
  assign ferr_o   = ferr_q;
  assign idwait_o = idw_q;
  assign line_o   = line_s;
endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctrl_wr_i,
  input logic [DW-1:0] rdata_o,
  input logic          full_o,
  input logic          ovr_o,
  input logic          ferr_o,
  input logic          idwait_o,
  input logic          frm_done
);
  // R2
  full_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(frm_done));

  // R4
  idw_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(idwait_o) && !$past(ctrl_wr_i)) |-> (full_o && $past(frm_done)));

  // R6
  ovr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(rdata_o));

  // R7
  ferr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ferr_o) |-> $stable(rdata_o));

  // R8
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o || ferr_o) |=> !$rose(full_o));
endmodule

bind mpr_rx mpr_rx_chk #(.DW(mpr_pkg::DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_wr_i(ctrl_wr_i),
  .rdata_o  (rdata_o),
  .full_o   (full_o),
  .ovr_o    (ovr_o),
  .ferr_o   (ferr_o),
  .idwait_o (idwait_o),
  .frm_done (frm_done)
);

// File: tb/sim_mpr_rx.sv
`timescale 1ns/1ps
module sim_mpr_rx;
  localparam int BIT_CYC = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       ctrl_wr_i = 1'b0, ctrl_wdata_i = 1'b0;
  logic       full_clr_i = 1'b0, ovr_clr_i = 1'b0, ferr_clr_i = 1'b0;
  logic [7:0] rdata_o;
  logic       full_o, ovr_o, ferr_o, idwait_o, line_o;

  int total = 0;
  int bad = 0;
  bit fin = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mpr_rx #(.CLK_DIV(1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .full_clr_i(full_clr_i), .ovr_clr_i(ovr_clr_i), .ferr_clr_i(ferr_clr_i),
    .rdata_o(rdata_o), .full_o(full_o), .ovr_o(ovr_o), .ferr_o(ferr_o),
    .idwait_o(idwait_o), .line_o(line_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic mark, input logic stop);
    logic [10:0] f;
    f = {stop, mark, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk_i) rxd_i = f[i];
      repeat (BIT_CYC - 1) @(negedge clk_i);
    end
    @(negedge clk_i) rxd_i = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk_i);
  endtask

  task automatic wr_idw(input logic v);
    @(negedge clk_i) begin ctrl_wr_i = 1'b1; ctrl_wdata_i = v; end
    @(negedge clk_i) ctrl_wr_i = 1'b0;
  endtask

  task automatic clr_full;
    @(negedge clk_i) full_clr_i = 1'b1;
    @(negedge clk_i) full_clr_i = 1'b0;
  endtask

  task automatic clr_ovr;
    @(negedge clk_i) ovr_clr_i = 1'b1;
    @(negedge clk_i) ovr_clr_i = 1'b0;
  endtask

  task automatic clr_ferr;
    @(negedge clk_i) ferr_clr_i = 1'b1;
    @(negedge clk_i) ferr_clr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(full_o == 0, "R1 full", full_o, 0);
    chk(ovr_o == 0 && ferr_o == 0, "R1 errors", {ovr_o, ferr_o}, 0);
    chk(idwait_o == 0, "R1 idwait", idwait_o, 0);
    chk(rdata_o == 8'h00, "R1 rdata", rdata_o, 0);
    chk(line_o == 1, "R1 line", line_o, 1);

    // R2 exhaustive byte sweep, address-mark alternates
    for (int v = 0; v < 256; v++) begin
      send(8'(v), v[0], 1'b1);
      chk(full_o == 1 && rdata_o == 8'(v), "R2 load", {full_o, rdata_o}, {1'b1, 8'(v)});
      clr_full();
    end
    // R9 receive-full clear touches nothing else
    chk(full_o == 0 && ovr_o == 0 && ferr_o == 0, "R9 full clear", {full_o, ovr_o, ferr_o}, 0);

    // R3 data frame dropped under ID-wait
    wr_idw(1'b1);
    send(8'hA5, 1'b0, 1'b1);
    chk(full_o == 0 && idwait_o == 1, "R3 flags", {full_o, idwait_o}, 2'b01);
    chk(rdata_o == 8'hFF, "R3 rdata", rdata_o, 8'hFF);
    chk(ovr_o == 0 && ferr_o == 0, "R3 errors", {ovr_o, ferr_o}, 0);

    // R4 ID frame accepted
    send(8'h3C, 1'b1, 1'b1);
    chk(full_o == 1 && rdata_o == 8'h3C, "R4 load", {full_o, rdata_o}, {1'b1, 8'h3C});
    chk(idwait_o == 0, "R4 idwait", idwait_o, 0);

    // R5 resume filtering
    wr_idw(1'b1);
    clr_full();
    send(8'h11, 1'b0, 1'b1);
    chk(full_o == 0 && rdata_o == 8'h3C, "R5 drop", {full_o, rdata_o}, {1'b0, 8'h3C});
    send(8'h42, 1'b1, 1'b1);
    chk(full_o == 1 && rdata_o == 8'h42 && idwait_o == 0, "R5 id",
        {full_o, idwait_o, rdata_o}, {2'b10, 8'h42});

    // R6 overrun
    send(8'h77, 1'b0, 1'b1);
    chk(ovr_o == 1 && rdata_o == 8'h42, "R6 overrun", {ovr_o, rdata_o}, {1'b1, 8'h42});

    // R8 halted while overrun pending
    clr_full();
    chk(ovr_o == 1, "R9 ovr kept", ovr_o, 1);
    send(8'h55, 1'b0, 1'b1);
    chk(full_o == 0 && rdata_o == 8'h42, "R8 halt ovr", {full_o, rdata_o}, {1'b0, 8'h42});
    clr_ovr();
    chk(ovr_o == 0 && ferr_o == 0, "R9 ovr clear", {ovr_o, ferr_o}, 0);
    send(8'h56, 1'b0, 1'b1);
    chk(full_o == 1 && rdata_o == 8'h56, "R8 resume", {full_o, rdata_o}, {1'b1, 8'h56});
    clr_full();

    // R7 framing error
    send(8'h99, 1'b0, 1'b0);
    chk(ferr_o == 1 && full_o == 0 && rdata_o == 8'h56, "R7 ferr",
        {ferr_o, full_o, rdata_o}, {2'b10, 8'h56});
    // R10 break visible on line level
    @(negedge clk_i) rxd_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk(line_o == 0, "R10 break", line_o, 0);
    @(negedge clk_i) rxd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(line_o == 1, "R10 idle", line_o, 1);
    chk(ferr_o == 1 && ovr_o == 0, "R8 no frame in break", {ferr_o, ovr_o}, 2'b10);

    // R8 halted while framing error pending
    send(8'h12, 1'b0, 1'b1);
    chk(full_o == 0 && rdata_o == 8'h56, "R8 halt ferr", {full_o, rdata_o}, {1'b0, 8'h56});
    clr_ferr();
    chk(ferr_o == 0, "R9 ferr clear", ferr_o, 0);
    send(8'h13, 1'b0, 1'b1);
    chk(full_o == 1 && rdata_o == 8'h13, "R8 resume ferr", {full_o, rdata_o}, {1'b1, 8'h13});
    clr_full();

    // R11 glitch rejection
    @(negedge clk_i) rxd_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (3 * BIT_CYC * 11) @(negedge clk_i);
    chk(full_o == 0 && ferr_o == 0 && ovr_o == 0, "R11 glitch",
        {full_o, ferr_o, ovr_o}, 0);
    send(8'hC3, 1'b1, 1'b1);
    chk(full_o == 1 && rdata_o == 8'hC3, "R11 after glitch", {full_o, rdata_o}, {1'b1, 8'hC3});

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule